// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-lane SPI master with three 32-bit registers on a simple register bus: a mode register, a transmit register and a receive register. The mode register sets clock polarity and phase, bit order, internal loopback, word length and the serial clock rate. The rate comes from a 4-bit prescale value and an optional extra divide-by-16 stage. Writing the transmit register while the unit is enabled and idle starts one word transfer. When the final clock edge has been issued, `done` rises and the received word can be read.

An alternate register mode moves the data lanes inside the transmit and receive registers. Short MSB-first words sit in the upper part of the register, and LSB-first received bytes sit at bit 8. The same mode halves the baud-generator input clock. Software clears the mode register before it writes a new configuration. Dropping the enable bit therefore aborts any transfer and returns the shifter and the clock to idle.

Top module: `spi_host_core`

## Requirements
- R1: After reset, `sck`, `mosi`, `busy`, `done` and `bus_rdata` are all 0.
- R2: Bus address 0 is the mode register and address 1 is the transmit register. A write to either reads back on `bus_rdata` one cycle after the address is presented. Address 2 returns the receive register and address 3 returns zero.
- R3: A transmit write while enable (mode bit 24) is set and `busy` is low raises `busy` on the next cycle. A transmit write while enable is clear starts nothing. A transmit write while `busy` is high changes neither the transmit register nor the transfer in flight.
- R4: Each SCK half period lasts 2·P·D·A clock cycles. P is the prescale field (bits 19:16), with 0 taken as 1. D is 16 when bit 27 is set and 1 otherwise. A is 2 when bit 14 (alternate mode) is set and 1 otherwise.
- R5: While no transfer runs, SCK rests at the level of mode bit 29. A transfer gives exactly one SCK pulse per data bit.
- R6: With bit 28 clear, the first bit is on MOSI before the first edge, MISO is sampled on leading edges, and MOSI changes on trailing edges. With bit 28 set, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R7: Mode bit 26 set shifts each word MSB first. Bit 26 clear shifts it LSB first.
- R8: Mode bit 30 feeds MOSI into the receive shifter, so MISO has no effect on the received word.
- R9: The length field (bits 23:20) holds the word length minus one for codes 3 to 15. Code 0 selects 32 bits, and codes 1 and 2 select 4 bits.
- R10: `done` rises and `busy` falls on the cycle of the final SCK edge, and the two are never high together. The next started transfer clears `done`.
- R11: In alternate mode with MSB-first order, the transmit word is taken from bit 24 for words of up to 8 bits and from bit 16 for words of 9 to 16 bits. It is taken from bit 0 for 32-bit words and for any LSB-first word. Outside alternate mode the transmit word is always taken from bit 0.
- R12: In alternate mode the received word is placed at bit 16 for MSB-first words of up to 16 bits and at bit 8 for LSB-first words of up to 8 bits. In every other case it is placed at bit 0, and unused receive bits read 0.
- R13: Clearing enable during a transfer drops `busy` and `done` and returns SCK to the level of bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 mode, 1 transmit, 2 receive |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word transfer is in progress |
| done | output | 1 | The last transfer has completed |

## Verification
A slave model runs transfers with each phase and polarity pair, both bit orders, and lengths of 4, 8, 12, 16 and 32 bits. It captures MOSI and drives MISO from a word that differs from the transmit word, so a swapped direction, a reversed order or an off-by-one edge shows up as a wrong word on one side. The alternate-mode runs use payloads placed in distinct lanes of the register, so each lane shift is told apart from the others. Loopback runs drive MISO high throughout to prove that the pin is ignored. The prescale and divide-by-16 settings are checked by timing every SCK edge. Separate runs cover aborting a transfer, a write while disabled and a write while busy.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  localparam int unsigned MB_LOOP   = 30;
  localparam int unsigned MB_CPOL   = 29;
  localparam int unsigned MB_CPHA   = 28;
  localparam int unsigned MB_DIV16  = 27;
  localparam int unsigned MB_MSB    = 26;
  localparam int unsigned MB_EN     = 24;
  localparam int unsigned MB_LEN    = 20;
  localparam int unsigned MB_PM     = 16;
  localparam int unsigned MB_ALT    = 14;
  localparam int unsigned LEN_CODE_W = 4;
  localparam int unsigned PM_W       = 4;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_TX   = 2'd1,
    ADDR_RX   = 2'd2,
    ADDR_NONE = 2'd3
  } spi_addr_e;

  typedef struct packed {
    logic                  loopback;
    logic                  cpol;
    logic                  cpha;
    logic                  div16;
    logic                  msb_first;
    logic                  alt;
    logic [LEN_CODE_W-1:0] len_code;
    logic [PM_W-1:0]       pm;
  } spi_cfg_t;

  // Word length in bits for a length code: 0 means 32, 1 and 2 clamp to 4.
  function automatic logic [5:0] word_bits(input logic [LEN_CODE_W-1:0] code);
    logic [5:0] n;
    if (code == '0)              n = 6'd32;
    else if (code < 4'd3)        n = 6'd4;
    else                         n = {2'b00, code} + 6'd1;
    return n;
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
`timescale 1ns/1ps
module spi_baud_gen #(
  parameter int unsigned PM_W       = 4,
  parameter int unsigned XDIV_LOG2  = 4,
  localparam int unsigned CNT_W     = PM_W + XDIV_LOG2 + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PM_W-1:0] pm,
  input  logic            div16,
  input  logic            alt,
  output logic            tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_len;
  logic [PM_W-1:0]  pm_eff;

  always_comb begin
    pm_eff   = (pm == '0) ? PM_W'(1) : pm;
    half_len = CNT_W'({pm_eff, 1'b0});
    if (div16) half_len = half_len << XDIV_LOG2;
    if (alt)   half_len = half_len << 1;
  end

  assign tick = run && (cnt_q == half_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spi_lane_align.sv
`timescale 1ns/1ps
module spi_lane_align #(
  parameter int unsigned W     = 32,
  localparam int unsigned LEN_W = $clog2(W) + 1,
  localparam int unsigned SH_W  = $clog2(W)
) (
  input  logic             alt,
  input  logic             msb_first,
  input  logic [LEN_W-1:0] nbits,
  input  logic [W-1:0]     tx_reg,
  input  logic [W-1:0]     rx_word,
  output logic [W-1:0]     tx_word,
  output logic [W-1:0]     rx_reg
);
  localparam int unsigned NARROW = 8;
  localparam int unsigned MID    = W / 2;
  localparam int unsigned HIGH   = W - NARROW;

  logic [W-1:0]    mask;
  logic [SH_W-1:0] tx_sh;
  logic [SH_W-1:0] rx_sh;
  logic            narrow;
  logic            mid;

  always_comb begin
    mask   = {W{1'b1}} >> (LEN_W'(W) - nbits);
    narrow = nbits <= LEN_W'(NARROW);
    mid    = nbits <= LEN_W'(MID);
    tx_sh  = '0;
    rx_sh  = '0;
    if (alt) begin
      if (msb_first) begin
        if (narrow)   tx_sh = SH_W'(HIGH);
        else if (mid) tx_sh = SH_W'(MID);
        if (mid)      rx_sh = SH_W'(MID);
      end else begin
        if (narrow)   rx_sh = SH_W'(NARROW);
      end
    end
    tx_word = (tx_reg >> tx_sh) & mask;
    rx_reg  = (rx_word & mask) << rx_sh;
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int unsigned W      = 32,
  localparam int unsigned IDX_W  = $clog2(W),
  localparam int unsigned LEN_W  = IDX_W + 1,
  localparam int unsigned EDGE_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic             tick,
  input  logic [LEN_W-1:0] nbits,
  input  logic             cpol,
  input  logic             cpol_live,
  input  logic             cpha,
  input  logic             msb_first,
  input  logic             loopback,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  logic [EDGE_W-1:0] edge_cnt;
  logic [LEN_W-1:0]  bit_cnt;
  logic [LEN_W-1:0]  bit_nxt;
  logic [W-1:0]      tx_q;
  logic              din;
  logic              leading;
  logic              last_edge;

  function automatic logic [IDX_W-1:0] wire_pos(input logic [LEN_W-1:0] b);
    logic [LEN_W-1:0] t;
    t = msb_first ? (nbits - LEN_W'(1) - b) : b;
    return t[IDX_W-1:0];
  endfunction

  assign din       = loopback ? mosi : miso;
  assign leading   = ~edge_cnt[0];
  assign last_edge = edge_cnt == ({nbits, 1'b0} - EDGE_W'(1));
  assign bit_nxt   = bit_cnt + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      edge_cnt <= '0;
      bit_cnt  <= '0;
      tx_q     <= '0;
      rx_word  <= '0;
    end else if (!enable) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sck      <= cpol_live;
      mosi     <= 1'b0;
      edge_cnt <= '0;
      bit_cnt  <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      sck      <= cpol;
      edge_cnt <= '0;
      bit_cnt  <= '0;
      tx_q     <= tx_word;
      rx_word  <= '0;
      if (!cpha) mosi <= tx_word[wire_pos('0)];
    end else if (busy && tick) begin
      sck      <= ~sck;
      edge_cnt <= edge_cnt + EDGE_W'(1);
      if (leading) begin
        if (!cpha) rx_word[wire_pos(bit_cnt)] <= din;
        else       mosi <= tx_q[wire_pos(bit_cnt)];
      end else begin
        if (!cpha) begin
          if (!last_edge) mosi <= tx_q[wire_pos(bit_nxt)];
        end else begin
          rx_word[wire_pos(bit_cnt)] <= din;
        end
        bit_cnt <= bit_nxt;
      end
      if (last_edge) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else if (!busy) begin
      sck <= cpol_live;
    end
  end

  // R6
  sck_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    busy && enable && !tick |=> $stable(sck));

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/spi_host_core.sv
`timescale 1ns/1ps
module spi_host_core
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              done
);
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] txreg_q;
  logic [DATA_W-1:0] tx_src;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] rx_view;
  spi_cfg_t          cfg_live;
  spi_cfg_t          cfg_q;
  spi_cfg_t          cfg_cur;
  logic              enable;
  logic              wr_mode;
  logic              wr_tx;
  logic              start;
  logic              tick;
  logic [LEN_W-1:0]  nbits;
  spi_addr_e         addr;

  assign addr   = spi_addr_e'(bus_addr);
  assign enable = mode_q[MB_EN];

  always_comb begin
    cfg_live.loopback  = mode_q[MB_LOOP];
    cfg_live.cpol      = mode_q[MB_CPOL];
    cfg_live.cpha      = mode_q[MB_CPHA];
    cfg_live.div16     = mode_q[MB_DIV16];
    cfg_live.msb_first = mode_q[MB_MSB];
    cfg_live.alt       = mode_q[MB_ALT];
    cfg_live.len_code  = mode_q[MB_LEN +: LEN_CODE_W];
    cfg_live.pm        = mode_q[MB_PM +: PM_W];
  end

  assign wr_mode = bus_we && (addr == ADDR_MODE);
  assign wr_tx   = bus_we && (addr == ADDR_TX) && !busy;
  assign start   = wr_tx && enable;
  assign cfg_cur = start ? cfg_live : cfg_q;
  assign nbits   = LEN_W'(word_bits(cfg_cur.len_code));
  assign tx_src  = start ? bus_wdata : txreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      txreg_q <= '0;
      cfg_q   <= '0;
    end else begin
      if (wr_mode) mode_q  <= bus_wdata;
      if (wr_tx)   txreg_q <= bus_wdata;
      if (start)   cfg_q   <= cfg_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (addr)
        ADDR_MODE: bus_rdata <= mode_q;
        ADDR_TX:   bus_rdata <= txreg_q;
        ADDR_RX:   bus_rdata <= rx_view;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  spi_baud_gen #(.PM_W(PM_W), .XDIV_LOG2(4)) u_baud (
    .clk   (clk),
    .rst   (rst),
    .run   (busy),
    .pm    (cfg_cur.pm),
    .div16 (cfg_cur.div16),
    .alt   (cfg_cur.alt),
    .tick  (tick)
  );

  spi_lane_align #(.W(DATA_W)) u_align (
    .alt       (cfg_cur.alt),
    .msb_first (cfg_cur.msb_first),
    .nbits     (nbits),
    .tx_reg    (tx_src),
    .rx_word   (rx_word),
    .tx_word   (tx_word),
    .rx_reg    (rx_view)
  );

  spi_shift_engine #(.W(DATA_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start     (start),
    .tick      (tick),
    .nbits     (nbits),
    .cpol      (cfg_cur.cpol),
    .cpol_live (cfg_live.cpol),
    .cpha      (cfg_cur.cpha),
    .msb_first (cfg_cur.msb_first),
    .loopback  (cfg_cur.loopback),
    .tx_word   (tx_word),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (busy),
    .done      (done),
    .rx_word   (rx_word)
  );

  // R3
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R13
  disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy && !done);
endmodule

// File: tb/spi_host_core_tb.sv
`timescale 1ns/1ps
module spi_host_core_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, busy, done;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int          n;
    bit          cpha;
    bit          msb;
    int          half;
    logic [31:0] exp_mosi;
    logic [31:0] slave;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  spi_host_core u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit loop, bit cpol, bit cpha, bit div16, bit msb,
                                     logic [3:0] len, logic [3:0] pm, bit alt);
    logic [31:0] m = 32'h0;
    m[30] = loop; m[29] = cpol; m[28] = cpha; m[27] = div16; m[26] = msb;
    m[24] = 1'b1; m[23:20] = len; m[19:16] = pm; m[14] = alt;
    return m;
  endfunction

  function automatic int nbits_of(logic [3:0] code);
    if (code == 0) return 32;
    if (code < 3)  return 4;
    return int'(code) + 1;
  endfunction

  function automatic logic [31:0] mask_of(int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [31:0] tx_of(logic [31:0] t, bit alt, bit msb, int n);
    int sh = 0;
    if (alt && msb) sh = (n <= 8) ? 24 : (n <= 16) ? 16 : 0;
    return (t >> sh) & mask_of(n);
  endfunction

  function automatic logic [31:0] rx_of(logic [31:0] r, bit alt, bit msb, int n);
    int sh = 0;
    if (alt) begin
      if (msb) sh = (n <= 16) ? 16 : 0;
      else     sh = (n <= 8) ? 8 : 0;
    end
    return (r & mask_of(n)) << sh;
  endfunction

  function automatic int wpos(item_t it, int i);
    return it.msb ? it.n - 1 - i : i;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_mode(input logic [31:0] m);
    bus_write(2'd0, 32'h0);
    bus_write(2'd0, m);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // Driver: configure, push expectation, start, then check the receive register.
  task automatic xfer(input logic [31:0] m, input logic [31:0] t, input logic [31:0] slave, input string tag);
    item_t it;
    logic [31:0] v, src, exp_rx;
    int pmv;
    bit alt;
    it.n    = nbits_of(m[23:20]);
    it.cpha = m[28];
    it.msb  = m[26];
    alt     = m[14];
    pmv     = (m[19:16] == 0) ? 1 : int'(m[19:16]);
    it.half = 2 * pmv * (m[27] ? 16 : 1) * (alt ? 2 : 1);
    it.exp_mosi = tx_of(t, alt, it.msb, it.n);
    it.slave    = slave & mask_of(it.n);
    src    = m[30] ? it.exp_mosi : it.slave;
    exp_rx = rx_of(src, alt, it.msb, it.n);
    set_mode(m);
    q.push_back(it);
    bus_write(2'd1, t);
    chk(busy === 1'b1 && done === 1'b0, {"R3 R10 start ", tag}, {30'b0, busy, done}, 32'h2);
    wait (done === 1'b1);
    idle(2);
    bus_read(2'd2, v);
    chk(v === exp_rx, {"rx word ", tag}, v, exp_rx);
  endtask

  // Monitor: slave model fed from the queue; checks MOSI word, edge timing, completion.
  initial begin
    item_t       it;
    realtime     tp;
    logic [31:0] cap;
    int          bad_gap;
    miso = 1'b0;
    forever begin
      @(posedge busy);
      #1;
      if (q.size() == 0) continue;
      it = q.pop_front();
      tp = $realtime; cap = '0; bad_gap = 0;
      if (!it.cpha) miso = it.slave[wpos(it, 0)];
      for (int i = 0; i < it.n; i++) begin
        @(sck); #1;
        if ($realtime - tp != it.half * 10.0) bad_gap++;
        tp = $realtime;
        if (!it.cpha) cap[wpos(it, i)] = mosi;
        else          miso = it.slave[wpos(it, i)];
        @(sck); #1;
        if ($realtime - tp != it.half * 10.0) bad_gap++;
        tp = $realtime;
        if (!it.cpha) begin
          if (i + 1 < it.n) miso = it.slave[wpos(it, i + 1)];
        end else begin
          cap[wpos(it, i)] = mosi;
        end
      end
      chk(busy === 1'b0 && done === 1'b1, "R10 done at final edge", {30'b0, busy, done}, 32'h1);
      chk(bad_gap == 0, "R4 R5 half period", bad_gap, 0);
      chk(cap === it.exp_mosi, "R6 R7 R11 mosi word", cap, it.exp_mosi);
    end
  end

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk({sck, mosi, busy, done} === 4'b0 && bus_rdata === 32'h0, "R1 reset", {sck, mosi, busy, done}, 0);

    // R2 readback
    bus_write(2'd0, 32'h0A0B_C0DE);
    bus_read(2'd0, v);
    chk(v === 32'h0A0B_C0DE, "R2 mode readback", v, 32'h0A0B_C0DE);
    bus_read(2'd3, v);
    chk(v === 32'h0, "R2 spare address", v, 0);

    // R3 write while disabled starts nothing
    bus_write(2'd0, 32'h0);
    bus_write(2'd1, 32'h55);
    idle(4);
    chk(busy === 1'b0, "R3 disabled write", busy, 0);
    bus_read(2'd1, v);
    chk(v === 32'h55, "R2 tx readback", v, 32'h55);

    // R5 idle level follows bit 29
    set_mode(mk(0, 1, 0, 0, 1, 4'd7, 4'd1, 0));
    idle(2);
    chk(sck === 1'b1, "R5 idle high", sck, 1);

    xfer(mk(0, 0, 0, 0, 1, 4'd7, 4'd1, 0), 32'hA5, 32'h3C, "R6 R7 mode0 msb");
    xfer(mk(0, 1, 1, 0, 0, 4'd7, 4'd3, 0), 32'h1E, 32'hC3, "R6 R7 mode3 lsb");
    xfer(mk(0, 1, 0, 0, 0, 4'd7, 4'd0, 0), 32'h6B, 32'h94, "R4 pm zero");
    xfer(mk(1, 0, 1, 1, 1, 4'd15, 4'd2, 0), 32'hBEEF, 32'hFFFF_FFFF, "R8 loopback div16");
    miso = 1'b1;
    xfer(mk(0, 0, 0, 0, 1, 4'd0, 4'd1, 0), 32'h1234_5678, 32'h9ABC_DEF0, "R9 32 bit");
    xfer(mk(1, 0, 0, 0, 1, 4'd3, 4'd1, 0), 32'hF9, 32'hF, "R9 4 bit");
    xfer(mk(1, 0, 0, 0, 0, 4'd1, 4'd1, 0), 32'h3A, 32'hF, "R9 code1 clamps");
    xfer(mk(0, 0, 0, 0, 1, 4'd7, 4'd1, 1), 32'hA500_0000, 32'h5A, "R11 R12 alt msb 8");
    xfer(mk(0, 0, 1, 0, 1, 4'd11, 4'd1, 1), 32'h0ABC_0000, 32'h123, "R11 R12 alt msb 12");
    xfer(mk(0, 0, 0, 0, 0, 4'd7, 4'd1, 1), 32'h0000_00C6, 32'h71, "R11 R12 alt lsb 8");
    xfer(mk(0, 1, 1, 0, 0, 4'd15, 4'd1, 1), 32'h0000_B00C, 32'h4D2E, "R11 R12 alt lsb 16");
    xfer(mk(0, 0, 0, 0, 1, 4'd0, 4'd1, 1), 32'hCAFE_F00D, 32'h0F1E_2D3C, "R11 R12 alt msb 32");

    // R3 write while busy ignored
    begin
      item_t it;
      set_mode(mk(0, 0, 0, 0, 1, 4'd7, 4'd2, 0));
      it.n = 8; it.cpha = 0; it.msb = 1; it.half = 4; it.exp_mosi = 32'h81; it.slave = 32'h18;
      q.push_back(it);
      bus_write(2'd1, 32'h81);
      bus_write(2'd1, 32'h7E);
      bus_read(2'd1, v);
      chk(v === 32'h81, "R3 busy write ignored", v, 32'h81);
      wait (done === 1'b1);
      idle(2);
      bus_read(2'd2, v);
      chk(v === 32'h18, "R3 rx after busy write", v, 32'h18);
      idle(10);
      chk(busy === 1'b0, "R3 no second transfer", busy, 0);
    end

    // R13 abort by clearing enable
    set_mode(mk(0, 0, 0, 1, 1, 4'd15, 4'd15, 0));
    bus_write(2'd1, 32'hFFFF);
    idle(100);
    chk(busy === 1'b1, "R13 running before abort", busy, 1);
    bus_write(2'd0, 32'h0);
    idle(2);
    chk({busy, done, sck} === 3'b000, "R13 abort", {busy, done, sck}, 0);

    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule